// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the slave-side bit and byte engine of a two-wire serial bus interface. It runs on a fast system clock and oversamples the bus clock and data lines. Both lines pass through a synchronizer and a stability filter. The block then finds bus clock edges and the START and STOP framing conditions. It shifts bytes in and out and drives the acknowledge bit through an open-drain pull-down.

The first byte of each transaction holds a fixed device-type nibble, three address bits and a direction bit. The three address bits are compared against strap pins. The block acknowledges its address only when the downstream unit is not busy, so a master can poll until a long internal write has finished. Bytes that are received and acknowledged go to a command unit as one-cycle pulses, each tagged with its position in the transaction. In read transactions the command unit supplies the outgoing bytes through a request pulse. The block does not interpret instructions and holds no register storage.

Top module: `twi_slave_frontend`

## Requirements
- R1: A falling data line while the clock line is high gives a one-cycle `start_o` pulse. A rising data line while the clock line is high gives a one-cycle `stop_o` pulse.
- R2: A low or high pulse on either bus line that lasts fewer than `FILT_CYCLES` system clocks is ignored and produces no START or STOP event.
- R3: After reset, and until a START is seen, clocked bus traffic produces no `rx_valid_o` pulse and no pull-down of the data line.
- R4: Bits are sampled on bus clock rising edges, most significant bit first. Each byte the block acknowledges appears on `rx_byte_o` with a one-cycle `rx_valid_o` pulse. At the same time `byte_index_o` holds the byte's position in the transaction, where 0 is the address byte.
- R5: The first byte after a START matches when bits 7:4 equal 4'b0101 and bits 3:1 equal `strap_addr_i`. Bit 0 is the direction (1 = read) and is shown on `rd_mode_o`. A matching byte is acknowledged by holding the data line low through the ninth clock. A non-matching byte gets no acknowledge and no `rx_valid_o`, and everything up to the next START is ignored.
- R6: If `busy_i` is high when a matching address byte completes, that byte is treated as a mismatch. Once `busy_i` is low, the same address is acknowledged.
- R7: After a matching address, every byte the master writes is acknowledged. In a read transaction, the first `RD_CMD_BYTES` bytes after the address are received and acknowledged as well.
- R8: In a read transaction, after those bytes, `tx_request_o` pulses for one cycle in the clock phase before each byte the block sends. `tx_byte_i` is sampled at the next bus clock falling edge and sent most significant bit first.
- R9: If the master acknowledges a sent byte (data line low at the ninth rising edge), the next byte is requested. If it does not, the block releases the line and stays idle until the next START.
- R10: `sda_drive_low_o` is the only data-line drive (1 pulls low, 0 releases). It is 0 after reset and changes only while the bus clock is low.
- R11: A STOP in the middle of a byte ends the transaction, and later bytes are ignored until a START. A START in the middle of a byte begins a fresh address phase, and byte positions restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_addr_i | input | 3 | Pin-strapped address bits |
| busy_i | input | 1 | Downstream unit busy; blocks address acknowledge |
| tx_byte_i | input | 8 | Byte to send, sampled after a request |
| sda_drive_low_o | output | 1 | Open-drain pull-down enable for the data line |
| rx_byte_o | output | 8 | Last acknowledged received byte |
| rx_valid_o | output | 1 | One-cycle pulse with a received byte |
| byte_index_o | output | IDXW | Position of the byte received or requested |
| rd_mode_o | output | 1 | Direction bit of the current transaction |
| tx_request_o | output | 1 | One-cycle request for the next byte to send |
| start_o | output | 1 | START event pulse |
| stop_o | output | 1 | STOP event pulse |

## Verification
A bit counter or state machine that is off by one shows up at the ports within one byte time. The acknowledge then falls in the wrong clock, or a read byte comes back shifted, and the master-side model sees this at its ninth sampling edge. A wrong match decision, or a busy check that is ignored, shows in the acknowledge bit of the address byte itself. A transaction state that is not cleared by a START or STOP shows in the next framed or unframed byte: the block either acknowledges a byte it should ignore or drops a valid address. Each received byte is compared through a queue of expected value-and-position pairs. Any lost, extra or misnumbered byte is therefore reported at the pulse where it occurs.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_LOAD
    } eng_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic        meta_q, sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            filt_o <= 1'b1;
            run_q  <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q != filt_o) begin
                if (run_q == CW'(FILT_CYCLES - 1)) begin
                    filt_o <= sync_q;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    generate
        if (FILT_CYCLES >= 2) begin : g_spacing_chk
            a_r2_no_back_to_back_toggle: assert property (@(posedge clk) disable iff (rst)
                !$stable(filt_o) |=> $stable(filt_o));
        end
    endgenerate

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f_i,
    input  logic    sda_f_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    always_comb begin
        ev_o.scl      = scl_f_i;
        ev_o.sda      = sda_f_i;
        ev_o.scl_rise = scl_f_i & ~scl_q;
        ev_o.scl_fall = ~scl_f_i & scl_q;
        ev_o.start    = scl_f_i & scl_q & sda_q & ~sda_f_i;
        ev_o.stop     = scl_f_i & scl_q & ~sda_q & sda_f_i;
    end

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
    import twi_pkg::*;
#(
    parameter int IDXW         = 4,
    parameter int RD_CMD_BYTES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_ev_t         ev_i,
    input  logic [2:0]      strap_addr_i,
    input  logic            busy_i,
    input  logic [7:0]      tx_byte_i,
    output logic            sda_low_o,
    output logic [7:0]      rx_byte_o,
    output logic            rx_valid_o,
    output logic [IDXW-1:0] byte_index_o,
    output logic            rd_mode_o,
    output logic            tx_request_o,
    output logic            start_o,
    output logic            stop_o
);
    localparam logic [IDXW-1:0] IDX_MAX = '1;

    eng_state_e      state;
    logic [7:0]      shreg;
    logic [3:0]      bitcnt;
    logic [IDXW-1:0] cnt;
    logic [IDXW-1:0] cnt_inc;
    logic [7:0]      rx_next;
    logic            tx_next;
    logic            addr_ok;

    always_comb begin
        rx_next = {shreg[6:0], ev_i.sda};
        cnt_inc = (cnt == IDX_MAX) ? cnt : cnt + 1'b1;
        tx_next = rd_mode_o && (cnt > IDXW'(RD_CMD_BYTES));
        addr_ok = addr_hit(rx_next, strap_addr_i) && !busy_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            cnt          <= '0;
            sda_low_o    <= 1'b0;
            rx_byte_o    <= '0;
            rx_valid_o   <= 1'b0;
            byte_index_o <= '0;
            rd_mode_o    <= 1'b0;
            tx_request_o <= 1'b0;
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
        end else begin
            rx_valid_o   <= 1'b0;
            tx_request_o <= 1'b0;
            start_o      <= ev_i.start;
            stop_o       <= ev_i.stop;
            if (ev_i.start) begin
                state     <= ST_RX;
                bitcnt    <= '0;
                cnt       <= '0;
                rd_mode_o <= 1'b0;
                sda_low_o <= 1'b0;
            end else if (ev_i.stop) begin
                state     <= ST_IDLE;
                sda_low_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev_i.scl_rise) begin
                            shreg  <= rx_next;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 4'd7) begin
                                if (cnt == '0 && !addr_ok) begin
                                    state <= ST_IDLE;
                                end else begin
                                    state        <= ST_ACK_SETUP;
                                    rx_byte_o    <= rx_next;
                                    rx_valid_o   <= 1'b1;
                                    byte_index_o <= cnt;
                                    cnt          <= cnt_inc;
                                    if (cnt == '0) rd_mode_o <= rx_next[0];
                                end
                            end
                        end
                    end
                    ST_ACK_SETUP: begin
                        if (ev_i.scl_fall) begin
                            sda_low_o <= 1'b1;
                            state     <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.scl_rise && tx_next) begin
                            tx_request_o <= 1'b1;
                            byte_index_o <= cnt;
                        end else if (ev_i.scl_fall) begin
                            bitcnt <= '0;
                            if (tx_next) begin
                                shreg     <= tx_byte_i;
                                sda_low_o <= ~tx_byte_i[7];
                                state     <= ST_TX;
                            end else begin
                                sda_low_o <= 1'b0;
                                state     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_i.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev_i.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_low_o <= 1'b0;
                                cnt       <= cnt_inc;
                                state     <= ST_MACK;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_low_o <= ~shreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev_i.scl_rise) begin
                            if (!ev_i.sda) begin
                                tx_request_o <= 1'b1;
                                byte_index_o <= cnt;
                                state        <= ST_LOAD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_LOAD: begin
                        if (ev_i.scl_fall) begin
                            shreg     <= tx_byte_i;
                            sda_low_o <= ~tx_byte_i[7];
                            bitcnt    <= '0;
                            state     <= ST_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    a_r10_idle_releases_line: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_low_o);

    a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low_o) |-> !ev_i.scl);

    a_r4_rx_follows_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(ev_i.scl_rise));

    a_r8_request_is_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_request_o |=> !tx_request_o);

    a_r11_start_restarts: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_RX && cnt == '0 && !sda_low_o));

endmodule

// File: rtl/twi_slave_frontend.sv
module twi_slave_frontend
    import twi_pkg::*;
#(
    parameter int FILT_CYCLES  = 3,
    parameter int IDXW         = 4,
    parameter int RD_CMD_BYTES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [2:0]      strap_addr_i,
    input  logic            busy_i,
    input  logic [7:0]      tx_byte_i,
    output logic            sda_drive_low_o,
    output logic [7:0]      rx_byte_o,
    output logic            rx_valid_o,
    output logic [IDXW-1:0] byte_index_o,
    output logic            rd_mode_o,
    output logic            tx_request_o,
    output logic            start_o,
    output logic            stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    bus_ev_t           ev;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_filt
            twi_line_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (raw_lines[g]),
                .filt_o (filt_lines[g])
            );
        end
    endgenerate

    twi_cond_detect cond_i (
        .clk     (clk),
        .rst     (rst),
        .scl_f_i (filt_lines[0]),
        .sda_f_i (filt_lines[1]),
        .ev_o    (ev)
    );

    twi_byte_engine #(.IDXW(IDXW), .RD_CMD_BYTES(RD_CMD_BYTES)) eng_i (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (ev),
        .strap_addr_i (strap_addr_i),
        .busy_i       (busy_i),
        .tx_byte_i    (tx_byte_i),
        .sda_low_o    (sda_drive_low_o),
        .rx_byte_o    (rx_byte_o),
        .rx_valid_o   (rx_valid_o),
        .byte_index_o (byte_index_o),
        .rd_mode_o    (rd_mode_o),
        .tx_request_o (tx_request_o),
        .start_o      (start_o),
        .stop_o       (stop_o)
    );

endmodule

// File: tb/twi_slave_frontend_tb_top.sv
module twi_slave_frontend_tb_top;
    localparam int H    = 20;
    localparam int IDXW = 4;
    localparam logic [2:0] STRAP  = 3'b101;
    localparam logic [7:0] ADDR_W = {4'b0101, STRAP, 1'b0};
    localparam logic [7:0] ADDR_R = {4'b0101, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic [7:0] tx_data = 8'h00;

    logic            sda_drive_low_o, rx_valid_o, rd_mode_o, tx_request_o, start_o, stop_o;
    logic [7:0]      rx_byte_o;
    logic [IDXW-1:0] byte_index_o;
    logic            sda_bus;

    assign sda_bus = sda_m & ~sda_drive_low_o;

    always #10 clk = ~clk;

    twi_slave_frontend #(.FILT_CYCLES(3), .IDXW(IDXW), .RD_CMD_BYTES(1)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_addr_i(STRAP), .busy_i(busy), .tx_byte_i(tx_data),
        .sda_drive_low_o(sda_drive_low_o), .rx_byte_o(rx_byte_o),
        .rx_valid_o(rx_valid_o), .byte_index_o(byte_index_o),
        .rd_mode_o(rd_mode_o), .tx_request_o(tx_request_o),
        .start_o(start_o), .stop_o(stop_o)
    );

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    int req_cnt = 0;
    int drive_viol = 0;
    logic [11:0] exp_q[$];
    logic [7:0]  tx_q[$];
    logic        prev_drive = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (start_o) start_cnt++;
            if (stop_o)  stop_cnt++;
            if (tx_request_o) begin
                req_cnt++;
                tx_data = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hEE;
            end
            if (sda_drive_low_o != prev_drive && scl_m) drive_viol++;
            prev_drive = sda_drive_low_o;
            if (rx_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected rx byte", {byte_index_o, rx_byte_o}, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check({byte_index_o, rx_byte_o} == e, "R4", "rx byte/index",
                          {byte_index_o, rx_byte_o}, e);
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; hold(4);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold(H);
            scl_m = 1'b1; hold(H);
            scl_m = 1'b0; hold(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H / 2);
        ack = ~sda_bus;
        hold(H / 2);
        scl_m = 1'b0; hold(4);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(H);
            scl_m = 1'b1; hold(H / 2);
            b[i] = sda_bus;
            hold(H / 2);
            scl_m = 1'b0; hold(4);
        end
        sda_m = ~mack; hold(H);
        scl_m = 1'b1; hold(H);
        scl_m = 1'b0; hold(4);
        sda_m = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic ack;
        logic [7:0] rb;
        int s0;
        hold(5);
        rst = 1'b0;
        hold(2);
        check(sda_drive_low_o == 1'b0, "R10", "reset drive", sda_drive_low_o, 0);
        check(rx_valid_o == 1'b0 && tx_request_o == 1'b0, "R4", "reset pulses",
              {rx_valid_o, tx_request_o}, 0);

        // R3: traffic before any START
        scl_m = 1'b0; hold(4);
        send_byte(ADDR_W, ack);
        check(ack == 1'b0, "R3", "ack without start", ack, 0);
        scl_m = 1'b1; hold(H);

        // R2: short glitch on data while clock high
        s0 = start_cnt;
        sda_m = 1'b0; hold(2);
        sda_m = 1'b1; hold(H);
        check(start_cnt == s0, "R2", "glitch start count", start_cnt, s0);

        // R1 R5 R7: write transaction
        s0 = start_cnt;
        bus_start();
        check(start_cnt == s0 + 1, "R1", "start pulse", start_cnt, s0 + 1);
        exp_q.push_back({4'd0, ADDR_W});
        send_byte(ADDR_W, ack);
        check(ack == 1'b1, "R5", "address ack", ack, 1);
        check(rd_mode_o == 1'b0, "R5", "write direction", rd_mode_o, 0);
        exp_q.push_back({4'd1, 8'hA0});
        send_byte(8'hA0, ack);
        check(ack == 1'b1, "R7", "instr ack", ack, 1);
        exp_q.push_back({4'd2, 8'h3C});
        send_byte(8'h3C, ack);
        check(ack == 1'b1, "R7", "data ack", ack, 1);
        exp_q.push_back({4'd3, 8'hC3});
        send_byte(8'hC3, ack);
        check(ack == 1'b1, "R7", "data2 ack", ack, 1);
        s0 = stop_cnt;
        bus_stop();
        check(stop_cnt == s0 + 1, "R1", "stop pulse", stop_cnt, s0 + 1);

        // R5: wrong strap, then wrong type nibble
        bus_start();
        send_byte({4'b0101, 3'b010, 1'b0}, ack);
        check(ack == 1'b0, "R5", "strap mismatch ack", ack, 0);
        send_byte(8'h00, ack);
        check(ack == 1'b0, "R5", "byte after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b0110, STRAP, 1'b0}, ack);
        check(ack == 1'b0, "R5", "type mismatch ack", ack, 0);
        bus_stop();

        // R6: busy polling
        busy = 1'b1;
        bus_start();
        send_byte(ADDR_W, ack);
        check(ack == 1'b0, "R6", "busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        exp_q.push_back({4'd0, ADDR_W});
        send_byte(ADDR_W, ack);
        check(ack == 1'b1, "R6", "ack after busy clear", ack, 1);
        bus_stop();

        // R8 R9: read transaction
        tx_q.push_back(8'hA5);
        tx_q.push_back(8'h3C);
        s0 = req_cnt;
        bus_start();
        exp_q.push_back({4'd0, ADDR_R});
        send_byte(ADDR_R, ack);
        check(ack == 1'b1, "R5", "read address ack", ack, 1);
        check(rd_mode_o == 1'b1, "R5", "read direction", rd_mode_o, 1);
        exp_q.push_back({4'd1, 8'h80});
        send_byte(8'h80, ack);
        check(ack == 1'b1, "R7", "read instr ack", ack, 1);
        read_byte(1'b1, rb);
        check(rb == 8'hA5, "R8", "first read byte", rb, 8'hA5);
        read_byte(1'b0, rb);
        check(rb == 8'h3C, "R9", "second read byte", rb, 8'h3C);
        check(req_cnt == s0 + 2, "R8", "request count", req_cnt, s0 + 2);
        read_byte(1'b0, rb);
        check(rb == 8'hFF, "R9", "released after nack", rb, 8'hFF);
        check(req_cnt == s0 + 2, "R9", "no request after nack", req_cnt, s0 + 2);
        bus_stop();

        // R11: STOP mid-byte, then unframed byte
        bus_start();
        exp_q.push_back({4'd0, ADDR_W});
        send_byte(ADDR_W, ack);
        send_bits(8'hFF, 4);
        bus_stop();
        scl_m = 1'b0; hold(4);
        send_byte(ADDR_W, ack);
        check(ack == 1'b0, "R11", "ignored after mid-byte stop", ack, 0);
        scl_m = 1'b1; hold(H);

        // R11: repeated START mid-byte
        bus_start();
        exp_q.push_back({4'd0, ADDR_W});
        send_byte(ADDR_W, ack);
        send_bits(8'h00, 3);
        bus_start();
        exp_q.push_back({4'd0, ADDR_W});
        send_byte(ADDR_W, ack);
        check(ack == 1'b1, "R11", "address after repeated start", ack, 1);
        exp_q.push_back({4'd1, 8'h77});
        send_byte(8'h77, ack);
        check(ack == 1'b1, "R11", "data after repeated start", ack, 1);
        bus_stop();
        hold(H);

        check(exp_q.size() == 0, "R4", "missing rx bytes", exp_q.size(), 0);
        check(drive_viol == 0, "R10", "drive changed with clock high", drive_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule